// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed engine that issues one serial flash command each time software asks for one. Software loads a command word that holds an opcode and a 24-bit flash address. It may also load a 32-bit data word. It then writes a control word that sets how many bytes go out, how many bytes come back, and a launch bit. The engine drives chip select, the serial clock and the serial output line. It shifts out between one and eight bytes and then captures up to four reply bytes into the data word. A busy flag stays set for the whole exchange, including a short idle gap after chip select is released.

The outgoing stream is taken from two sources. The command word supplies the opcode and then the address, most significant byte first. The data word follows, lowest byte first. One transmit count covers the whole stream, so a status read, a signature read, an erase and a four-byte program all use the same sequencer. The serial clock runs in mode 0 and is derived from the system clock by a half-period parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy reads 0, and the command, control and data registers read 0.
- R2: Register address 0 is the command word (opcode in bits 7:0, address in bits 31:8). Address 1 is the control word: transmit count in bits 3:0, receive count in bits 7:4, launch in bit 8 (write only, reads 0) and busy in bit 9 (read only). Address 2 is the data word. Address 3 reads 0. Written fields read back unchanged.
- R3: Bytes go out in this order: opcode, address bits 31:24, 23:16, 15:8, then data bits 7:0, 15:8, 23:16, 31:24. Each byte goes out most significant bit first.
- R4: The transmit count T includes the opcode. T=1 sends the opcode alone, T=4 adds the three address bytes, and T=4+N adds N data bytes. The clock gives exactly 8×(T+R) rising edges per transaction, where R is the effective receive count.
- R5: The serial output reads 0 during reply bytes. Reply byte j lands in data bits 8j+7:8j, and the data bits above the last reply byte are cleared. A receive count above 4 acts as 4. A receive count of 0 leaves the data word unchanged.
- R6: Mode 0 timing. The serial output changes only while the clock is low. The input is sampled on the rising clock edge. The clock is low whenever chip select is high. A rising clock edge only occurs after chip select has already been low for a cycle.
- R7: Busy reads 1 in the cycle after an accepted launch and stays 1 until the transaction ends. Chip select is low only while busy.
- R8: After chip select rises, busy stays set for at least one full serial clock period. Back-to-back transactions are therefore separated by at least 2×SCK_HALF system cycles with chip select high.
- R9: While busy is set, register writes and launch requests are ignored.
- R10: A launch with a transmit count of 0 or greater than 8 is ignored: busy stays 0 and chip select does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A flash model in the bench records every bit seen on a rising clock edge and drives reply bits on falling edges. The bench then checks the byte order and the edge count for transmit lengths of 1, 4, 6 and 8. A design with the address bytes reversed, or with the data word sent high byte first, shows wrong bytes at known stream positions. An off-by-one in the bit counter shows up as a wrong edge count. Reply placement is checked with a data word preloaded to all ones: a design that does not clear the upper bytes, or that places reply bytes in reverse, reads back the wrong word. A receive count of 7 checks that the count is clamped to 4. Illegal transmit counts, writes made while busy, and back-to-back launches are also exercised. A design that accepts them would show an extra chip-select fall, corrupted registers, or an idle gap that is too short.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int CTRL_LAUNCH_BIT = 8;
    localparam int CTRL_BUSY_BIT   = 9;
    localparam int MAX_TX_BYTES    = 8;
    localparam int MAX_RX_BYTES    = 4;

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = (!en || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  logic [3:0]  tx_cnt,
    input  logic [3:0]  rx_cnt,
    input  logic [31:0] cmd_word,
    input  logic [31:0] data_word,
    input  logic        miso,
    output logic        busy,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    output logic        rx_load,
    output logic [31:0] rx_word
);
    localparam int BW = $clog2((MAX_TX_BYTES + MAX_RX_BYTES) * 8 + 1);

    typedef struct packed {
        seq_state_e        st;
        logic              sck;
        logic              cs_n;
        logic [BW-1:0]     done;
        logic [BW-1:0]     total;
        logic [BW-1:0]     txbits;
        logic [63:0]       txv;
        logic [31:0]       rxsr;
        logic [2:0]        rxn;
        logic              gap;
        logic              load;
        logic [31:0]       rword;
    } seq_t;

    seq_t q, d;
    logic [2:0] rxn_c;
    logic       rise;

    function automatic logic [31:0] place_bytes(input logic [31:0] sr, input logic [2:0] n);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < MAX_RX_BYTES; j++) begin
            if (j < int'(n)) r[j*8 +: 8] = sr[(int'(n) - 1 - j)*8 +: 8];
        end
        return r;
    endfunction

    always_comb begin
        d      = q;
        d.load = 1'b0;
        rxn_c  = (rx_cnt > 4'd4) ? 3'd4 : rx_cnt[2:0];
        rise   = tick && ((q.st == ST_SETUP) || (q.st == ST_SHIFT && !q.sck));

        if (rise) begin
            d.sck = 1'b1;
            if (q.done >= q.txbits) d.rxsr = {q.rxsr[30:0], miso};
        end

        case (q.st)
            ST_IDLE: if (start) begin
                d.st     = ST_SETUP;
                d.cs_n   = 1'b0;
                d.sck    = 1'b0;
                d.done   = '0;
                d.rxn    = rxn_c;
                d.txbits = BW'(tx_cnt) << 3;
                d.total  = (BW'(tx_cnt) + BW'(rxn_c)) << 3;
                d.txv    = {cmd_word[7:0], cmd_word[31:24], cmd_word[23:16], cmd_word[15:8],
                            data_word[7:0], data_word[15:8], data_word[23:16], data_word[31:24]};
                d.rxsr   = '0;
            end
            ST_SETUP: if (tick) d.st = ST_SHIFT;
            ST_SHIFT: if (tick && q.sck) begin
                d.sck  = 1'b0;
                d.done = q.done + BW'(1);
                d.txv  = {q.txv[62:0], 1'b0};
                if (q.done + BW'(1) == q.total) begin
                    d.st    = ST_HOLD;
                    d.load  = (q.rxn != 3'd0);
                    d.rword = place_bytes(q.rxsr, q.rxn);
                end
            end
            ST_HOLD: if (tick) begin
                d.cs_n = 1'b1;
                d.gap  = 1'b0;
                d.st   = ST_GAP;
            end
            ST_GAP: if (tick) begin
                if (q.gap) begin
                    d.st   = ST_IDLE;
                    d.done = '0;
                    d.txbits = '0;
                end else begin
                    d.gap = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign cs_n    = q.cs_n;
    assign sck     = q.sck;
    assign mosi    = (q.done < q.txbits) ? q.txv[63] : 1'b0;
    assign rx_load = q.load;
    assign rx_word = q.rword;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] data;
        logic [3:0]  tx;
        logic [3:0]  rx;
    } regs_t;

    regs_t       q, d;
    logic        busy;
    logic        tick;
    logic        wr_ok;
    logic        launch;
    logic        rx_load;
    logic [31:0] rx_word;
    logic        unused_wr_hi;

    assign unused_wr_hi = ^wr_data[31:CTRL_BUSY_BIT];

    always_comb begin
        d      = q;
        wr_ok  = wr_en && !busy;
        launch = wr_ok && (wr_addr == REG_CTRL) && wr_data[CTRL_LAUNCH_BIT] &&
                 (wr_data[3:0] != 4'd0) && (wr_data[3:0] <= 4'(MAX_TX_BYTES));
        if (wr_ok) begin
            case (wr_addr)
                REG_CMD:  d.cmd  = wr_data;
                REG_CTRL: begin
                    d.tx = wr_data[3:0];
                    d.rx = wr_data[7:4];
                end
                REG_DATA: d.data = wr_data;
                default:  ;
            endcase
        end
        if (rx_load) d.data = rx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rd_addr)
            REG_CMD:  rd_data = q.cmd;
            REG_CTRL: rd_data = {22'd0, busy, 1'b0, q.rx, q.tx};
            REG_DATA: rd_data = q.data;
            default:  rd_data = '0;
        endcase
    end

    spi_cmd_tick #(.HALF(SCK_HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    spi_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (launch),
        .tx_cnt   (wr_data[3:0]),
        .rx_cnt   (wr_data[7:4]),
        .cmd_word (q.cmd),
        .data_word(q.data),
        .miso     (spi_miso),
        .busy     (busy),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .rx_load  (rx_load),
        .rx_word  (rx_word)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi,
    input logic        busy
);
    logic launch_req;
    logic bad_count;
    assign launch_req = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_LAUNCH_BIT] && !busy;
    assign bad_count  = (wr_data[3:0] == 4'd0) || (wr_data[3:0] > 4'd8);

    // R6
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R6
    sck_rise_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> (!spi_cs_n && $past(!spi_cs_n)));

    // R7
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && !bad_count) |=> busy);

    // R10
    bad_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && bad_count) |=> !busy);

    // R8
    gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> busy);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .spi_cs_n(spi_cs_n),
    .spi_sck (spi_sck),
    .spi_mosi(spi_mosi),
    .busy    (busy)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.SCK_HALF(HALF)) u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model
    logic       mosi_log [128];
    logic [7:0] rep [16];
    int         bitpos = 0;
    int         cs_falls = 0;
    int         hi_cnt = 0;
    int         last_gap = 0;

    function automatic logic rep_bit(input int b);
        if (b >= 128) return 1'b0;
        return rep[b >> 3][7 - (b & 7)];
    endfunction

    always @(negedge spi_cs_n) begin
        bitpos = 0;
        cs_falls++;
        spi_miso = rep_bit(0);
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (bitpos < 128) mosi_log[bitpos] = spi_mosi;
        bitpos++;
    end
    always @(negedge spi_sck) if (!spi_cs_n) spi_miso = rep_bit(bitpos);

    always @(posedge clk) begin
        if (spi_cs_n) hi_cnt++;
        else begin
            if (hi_cnt > 0) last_gap = hi_cnt;
            hi_cnt = 0;
        end
    end

    function automatic logic [7:0] sent_byte(input int k);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7 - i] = mosi_log[8*k + i];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #0.5 v = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(2'd1, v);
            if (!v[9]) return;
        end
        chk("R7 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic run_cmd(input logic [31:0] c, input logic [31:0] dw,
                           input logic [3:0] tx, input logic [3:0] rx);
        reg_wr(2'd0, c);
        reg_wr(2'd2, dw);
        reg_wr(2'd1, {23'd0, 1'b1, rx, tx});
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        chk("R1 sck", {31'd0, spi_sck}, 32'd0);
        reg_rd(2'd0, v); chk("R1 cmd", v, 32'd0);
        reg_rd(2'd1, v); chk("R1 ctrl", v, 32'd0);
        reg_rd(2'd2, v); chk("R1 data", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_wr(2'd0, 32'hA1B2C3D4);
        reg_wr(2'd2, 32'h11223344);
        reg_wr(2'd1, 32'h0000_0053);
        reg_rd(2'd0, v); chk("R2 cmd readback", v, 32'hA1B2C3D4);
        reg_rd(2'd2, v); chk("R2 data readback", v, 32'h11223344);
        reg_rd(2'd1, v); chk("R2 ctrl readback", v, 32'h53);
        reg_rd(2'd3, v); chk("R2 unused address", v, 32'd0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        rep[1] = 8'h5A;
        run_cmd(32'h0000_0005, 32'hFFFF_FFFF, 4'd1, 4'd1);
        chk("R4 status opcode", {24'd0, sent_byte(0)}, 32'h05);
        chk("R4 status edges", bitpos, 32'd16);
        chk("R5 status mosi low in reply", {24'd0, sent_byte(1)}, 32'h00);
        reg_rd(2'd2, v); chk("R5 status reply cleared upper", v, 32'h5A);
    endtask

    task automatic t_sig();
        logic [31:0] v;
        rep[4] = 8'h14;
        run_cmd(32'h1234_56AB, 32'h0, 4'd4, 4'd1);
        chk("R3 sig byte0", {24'd0, sent_byte(0)}, 32'hAB);
        chk("R3 sig byte1", {24'd0, sent_byte(1)}, 32'h12);
        chk("R3 sig byte2", {24'd0, sent_byte(2)}, 32'h34);
        chk("R3 sig byte3", {24'd0, sent_byte(3)}, 32'h56);
        chk("R4 sig edges", bitpos, 32'd40);
        reg_rd(2'd2, v); chk("R5 sig reply", v, 32'h14);
    endtask

    task automatic t_prog();
        logic [31:0] v;
        logic [7:0] exp_b [8] = '{8'h02, 8'h00, 8'h01, 8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
        run_cmd(32'h0001_0002, 32'hDDCC_BBAA, 4'd8, 4'd0);
        for (int k = 0; k < 8; k++) chk("R3 program byte", {24'd0, sent_byte(k)}, {24'd0, exp_b[k]});
        chk("R4 program edges", bitpos, 32'd64);
        reg_rd(2'd2, v); chk("R5 rx0 keeps data", v, 32'hDDCC_BBAA);
    endtask

    task automatic t_rx4();
        logic [31:0] v;
        rep[6] = 8'h11; rep[7] = 8'h22; rep[8] = 8'h33; rep[9] = 8'h44;
        run_cmd(32'hC0DE_0F9A, 32'h0000_BEEF, 4'd6, 4'd4);
        chk("R3 tx6 data byte0", {24'd0, sent_byte(4)}, 32'hEF);
        chk("R3 tx6 data byte1", {24'd0, sent_byte(5)}, 32'hBE);
        chk("R4 tx6 rx4 edges", bitpos, 32'd80);
        reg_rd(2'd2, v); chk("R5 rx4 placement", v, 32'h4433_2211);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        rep[1] = 8'hA5; rep[2] = 8'h5A; rep[3] = 8'h3C; rep[4] = 8'hC3;
        run_cmd(32'h0000_009F, 32'h0, 4'd1, 4'd7);
        chk("R5 rx clamp edges", bitpos, 32'd40);
        reg_rd(2'd2, v); chk("R5 rx clamp data", v, 32'hC33C_5AA5);
    endtask

    task automatic t_bad();
        logic [31:0] v;
        int falls0;
        falls0 = cs_falls;
        reg_wr(2'd1, 32'h0000_0110);
        reg_rd(2'd1, v); chk("R10 tx0 busy", {31'd0, v[9]}, 32'd0);
        reg_wr(2'd1, 32'h0000_0109);
        reg_rd(2'd1, v); chk("R10 tx9 busy", {31'd0, v[9]}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R10 no cs activity", cs_falls - falls0, 32'd0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int falls0;
        reg_wr(2'd0, 32'h0055_66C7);
        reg_wr(2'd2, 32'h8765_4321);
        falls0 = cs_falls;
        reg_wr(2'd1, 32'h0000_0108);
        chk("R7 busy after launch", {31'd0, rd_data[9]}, 32'd1);
        reg_wr(2'd0, 32'hFFFF_FFFF);
        reg_wr(2'd2, 32'h0);
        reg_wr(2'd1, 32'h0000_0101);
        wait_idle();
        chk("R9 one transaction", cs_falls - falls0, 32'd1);
        chk("R9 stream unaffected", {24'd0, sent_byte(7)}, 32'h87);
        reg_rd(2'd0, v); chk("R9 cmd kept", v, 32'h0055_66C7);
        reg_rd(2'd2, v); chk("R9 data kept", v, 32'h8765_4321);
        reg_rd(2'd1, v); chk("R9 ctrl kept", v[7:0], 32'h08);
    endtask

    task automatic t_gap();
        run_cmd(32'h0000_0006, 32'h0, 4'd1, 4'd0);
        reg_wr(2'd1, 32'h0000_0101);
        wait_idle();
        n_chk++;
        if (last_gap < 2*HALF) begin
            n_fail++;
            $display("FAIL R8 idle gap actual=%0d expected>=%0d", last_gap, 2*HALF);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 16; i++) rep[i] = 8'h00;
        for (int i = 0; i < 128; i++) mosi_log[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_status();
        t_sig();
        t_prog();
        t_rx4();
        t_clamp();
        t_bad();
        t_busy();
        t_gap();
        finish_up();
    end
endmodule